// File: doc/BRIEF.md
# Primed Depth Incrementing Pipeline

This block is a linear chain of pixel processors that carries plane depth values along a scan path. Every entry describes one plane of a display list. It holds a 16-bit depth taken at a reference pixel, a 16-bit per-pixel increment, start and end markers, a null marker for padding, and the list length. Entries move one stage per clock. Once an entry reaches the stage where its list begins evaluation, each further move adds or subtracts the increment. Neighbouring stages therefore hold the same plane at neighbouring pixel positions. Because every stage can subtract as well as add, the pipe can follow any linear step sequence across the screen, not only raster order.

A list of length L starts evaluating at the stage L positions from the end of the pipe. Before that stage, its entries travel passively: they are not incremented and their outputs are masked. A direction word (one bit per stage) is captured with each list head and sent down a priming channel. That channel moves two stages per clock, so it stays ahead of its list. Every stage keeps one direction bit for each of two list tags. Two overlapping lists can therefore run back to back with different step directions. Only the list that currently occupies the tail stage is allowed to drive valid outputs. A short list can be padded with null entries up to pipe length and cycled by the feeder until enough pixels have been produced.

Top module: `depth_pipe`

## Requirements
- R1: When a valid entry moves from an evaluating stage s-1 into stage s, its depth becomes depth+incr if its list's direction bit for stage s is 0, or depth-incr if that bit is 1. The arithmetic is modulo 2^16. Bit s of the direction word sampled with the list head is the bit for stage s.
- R2: A list with length field len_m1 (length len_m1+1) begins evaluating at stage N-1-len_m1. That stage holds the reference depth unchanged, so stage N-1 shows the reference plus (len_m1) signed steps.
- R3: The direction word is sampled only when in_valid and in_first are both 1, and it applies to that list alone. A list entered right behind another list does not change the earlier list's depths.
- R4: While an entry sits in a stage below its list's start stage, its depth passes from stage to stage unchanged.
- R5: out_mask[s] is 1 only for a valid entry at or beyond its list's start stage.
- R6: out_mask[s] is 1 only when stage N-1 holds a valid entry of the same list as stage s. Entries of a following list stay masked.
- R7: An entry entered with in_null=1 never raises its stage's mask bit.
- R8: After synchronous reset, all mask bits and both tail flags are 0, and entries in flight are discarded.
- R9: An entry accepted at a clock edge is in stage 0 after that edge and in stage N-1 after N edges. out_tail_first and out_tail_last show the start and end markers of a valid entry in stage N-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Entry present at the head this cycle |
| in_first | input | 1 | Entry is the first plane of a list (samples the direction word) |
| in_last | input | 1 | Entry is the last plane of a list |
| in_null | input | 1 | Entry is padding |
| in_len_m1 | input | 3 | List length minus one |
| in_depth | input | 16 | Plane depth at the reference pixel |
| in_incr | input | 16 | Per-pixel depth increment |
| in_dirs | input | 8 | Direction word, bit s for stage s, 1 = subtract |
| out_depth | output | 128 | Depth held by each stage, stage s in bits [16s+15:16s] |
| out_mask | output | 8 | Per-stage valid output flag |
| out_tail_first | output | 1 | Stage N-1 holds a valid list-start entry |
| out_tail_last | output | 1 | Stage N-1 holds a valid list-end entry |

## Verification
The bench builds the block at its defaults: eight stages, 16-bit depths and a 3-bit length field. With these values, a full-length list that evaluates from stage 0 and a one-plane list that evaluates only at the tail both fit in a run of a few cycles. The eight stages also cover both the stage pairs where the head takes its direction straight from the priming channel and the later stages where the direction comes from the latched copy. The 16-bit width makes wrap-around on add and subtract easy to reach. Two lists with opposite directions are entered back to back, so the second priming word overtakes the first list while that list is still inside the pipe.

// File: rtl/dpp_pkg.sv
package dpp_pkg;

    parameter int unsigned DEPTH_W = 16;
    parameter int unsigned LEN_W   = 3;

    typedef struct packed {
        logic               valid;
        logic               first;
        logic               last;
        logic               nul;
        logic               tag;
        logic [LEN_W-1:0]   len_m1;
        logic [DEPTH_W-1:0] depth;
        logic [DEPTH_W-1:0] incr;
    } pe_entry_t;

    // A stage evaluates an entry once it is at or past the list's start stage.
    function automatic logic stage_active(input int s, input logic [LEN_W-1:0] len_m1,
                                          input int n);
        return (s + int'(len_m1)) >= (n - 1);
    endfunction

endpackage

// File: rtl/dpp_prime_chain.sv
module dpp_prime_chain
    import dpp_pkg::*;
#(
    parameter int NUM_STAGES = 8,
    localparam int SLOTS = (NUM_STAGES + 1) / 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic                  tag_in,
    input  logic [NUM_STAGES-1:0] dirs_in,
    output logic [SLOTS-1:0]      slot_v,
    output logic [SLOTS-1:0]      slot_tag,
    output logic [NUM_STAGES-1:0] slot_dirs [SLOTS]
);

    // Each slot spans two stages, so one hop per clock is two stages per clock.
    generate
        for (genvar j = 0; j < SLOTS; j++) begin : g_slot
            if (j == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) begin
                        slot_v[0]    <= 1'b0;
                        slot_tag[0]  <= 1'b0;
                        slot_dirs[0] <= '0;
                    end else begin
                        slot_v[0]    <= load;
                        slot_tag[0]  <= tag_in;
                        slot_dirs[0] <= dirs_in;
                    end
                end
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (rst) begin
                        slot_v[j]    <= 1'b0;
                        slot_tag[j]  <= 1'b0;
                        slot_dirs[j] <= '0;
                    end else begin
                        slot_v[j]    <= slot_v[j-1];
                        slot_tag[j]  <= slot_tag[j-1];
                        slot_dirs[j] <= slot_dirs[j-1];
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/dpp_stage.sv
module dpp_stage
    import dpp_pkg::*;
#(
    parameter int NUM_STAGES = 8,
    parameter int IDX        = 0
) (
    input  logic      clk,
    input  logic      rst,
    input  pe_entry_t ent_in,
    input  logic      prime_v,
    input  logic      prime_tag,
    input  logic      prime_dir,
    output pe_entry_t ent_q
);

    logic      dir_q [2];
    logic      eff_dir;
    logic      step;
    pe_entry_t nxt;

    always_comb begin
        // A priming word passing this cycle wins over the stored copy.
        eff_dir = (prime_v && (prime_tag == ent_in.tag)) ? prime_dir : dir_q[ent_in.tag];
        step    = (IDX > 0) && ent_in.valid && stage_active(IDX - 1, ent_in.len_m1, NUM_STAGES);
        nxt     = ent_in;
        if (step) begin
            nxt.depth = eff_dir ? (ent_in.depth - ent_in.incr) : (ent_in.depth + ent_in.incr);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_q    <= '0;
            dir_q[0] <= 1'b0;
            dir_q[1] <= 1'b0;
        end else begin
            ent_q <= nxt;
            if (prime_v) begin
                dir_q[prime_tag] <= prime_dir;
            end
        end
    end

endmodule

// File: rtl/depth_pipe.sv
module depth_pipe
    import dpp_pkg::*;
#(
    parameter int NUM_STAGES = 8,
    localparam int SLOTS = (NUM_STAGES + 1) / 2
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            in_valid,
    input  logic                            in_first,
    input  logic                            in_last,
    input  logic                            in_null,
    input  logic [LEN_W-1:0]                in_len_m1,
    input  logic [DEPTH_W-1:0]              in_depth,
    input  logic [DEPTH_W-1:0]              in_incr,
    input  logic [NUM_STAGES-1:0]           in_dirs,
    output logic [NUM_STAGES*DEPTH_W-1:0]   out_depth,
    output logic [NUM_STAGES-1:0]           out_mask,
    output logic                            out_tail_first,
    output logic                            out_tail_last
);

    logic                  cur_tag;
    logic                  head;
    pe_entry_t             head_ent;
    pe_entry_t             stage_q [NUM_STAGES];
    logic [SLOTS-1:0]      slot_v;
    logic [SLOTS-1:0]      slot_tag;
    logic [NUM_STAGES-1:0] slot_dirs [SLOTS];

    assign head = in_valid && in_first;

    always_comb begin
        head_ent.valid  = in_valid;
        head_ent.first  = in_first;
        head_ent.last   = in_last;
        head_ent.nul    = in_null;
        head_ent.tag    = head ? ~cur_tag : cur_tag;
        head_ent.len_m1 = in_len_m1;
        head_ent.depth  = in_depth;
        head_ent.incr   = in_incr;
    end

    // One tag bit tells apart the list at the tail from the list behind it.
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_tag <= 1'b0;
        end else if (head) begin
            cur_tag <= ~cur_tag;
        end
    end

    dpp_prime_chain #(.NUM_STAGES(NUM_STAGES)) u_prime (
        .clk       (clk),
        .rst       (rst),
        .load      (head),
        .tag_in    (~cur_tag),
        .dirs_in   (in_dirs),
        .slot_v    (slot_v),
        .slot_tag  (slot_tag),
        .slot_dirs (slot_dirs)
    );

    generate
        for (genvar s = 0; s < NUM_STAGES; s++) begin : g_pe
            pe_entry_t feed;
            if (s == 0) begin : g_first
                assign feed = head_ent;
            end else begin : g_next
                assign feed = stage_q[s-1];
            end

            dpp_stage #(.NUM_STAGES(NUM_STAGES), .IDX(s)) u_stage (
                .clk       (clk),
                .rst       (rst),
                .ent_in    (feed),
                .prime_v   (slot_v[s/2]),
                .prime_tag (slot_tag[s/2]),
                .prime_dir (slot_dirs[s/2][s]),
                .ent_q     (stage_q[s])
            );

            assign out_depth[s*DEPTH_W +: DEPTH_W] = stage_q[s].depth;
            assign out_mask[s] = stage_q[s].valid && !stage_q[s].nul
                               && stage_active(s, stage_q[s].len_m1, NUM_STAGES)
                               && stage_q[NUM_STAGES-1].valid
                               && (stage_q[s].tag == stage_q[NUM_STAGES-1].tag);
        end
    endgenerate

    assign out_tail_first = stage_q[NUM_STAGES-1].valid && stage_q[NUM_STAGES-1].first;
    assign out_tail_last  = stage_q[NUM_STAGES-1].valid && stage_q[NUM_STAGES-1].last;

endmodule

// File: rtl/dpp_checker.sv
module dpp_checker
    import dpp_pkg::*;
#(
    parameter int NUM_STAGES = 8
) (
    input logic                  clk,
    input logic                  rst,
    input pe_entry_t             ent [NUM_STAGES],
    input logic [NUM_STAGES-1:0] out_mask
);

    generate
        for (genvar s = 0; s < NUM_STAGES; s++) begin : g_chk
            if (s > 0) begin : g_move
                p_step_r1: assert property (@(posedge clk) disable iff (rst)
                    (ent[s-1].valid && stage_active(s - 1, ent[s-1].len_m1, NUM_STAGES))
                    |=> ((ent[s].depth == DEPTH_W'($past(ent[s-1].depth) + $past(ent[s-1].incr)))
                      || (ent[s].depth == DEPTH_W'($past(ent[s-1].depth) - $past(ent[s-1].incr)))));

                p_passive_r4: assert property (@(posedge clk) disable iff (rst)
                    (ent[s-1].valid && !stage_active(s - 1, ent[s-1].len_m1, NUM_STAGES))
                    |=> (ent[s].depth == $past(ent[s-1].depth)));

                p_shift_r9: assert property (@(posedge clk) disable iff (rst)
                    ent[s-1].valid |=> (ent[s].valid && (ent[s].tag == $past(ent[s-1].tag))
                                        && (ent[s].nul == $past(ent[s-1].nul))));
            end

            p_mask_active_r5: assert property (@(posedge clk) disable iff (rst)
                out_mask[s] |-> (ent[s].valid && stage_active(s, ent[s].len_m1, NUM_STAGES)));

            p_tail_only_r6: assert property (@(posedge clk) disable iff (rst)
                out_mask[s] |-> (ent[NUM_STAGES-1].valid && (ent[s].tag == ent[NUM_STAGES-1].tag)));

            p_null_quiet_r7: assert property (@(posedge clk) disable iff (rst)
                (ent[s].valid && ent[s].nul) |-> !out_mask[s]);
        end
    endgenerate

    p_reset_clear_r8: assert property (@(posedge clk) rst |=> (out_mask == '0));

endmodule

bind depth_pipe dpp_checker #(.NUM_STAGES(NUM_STAGES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ent      (stage_q),
    .out_mask (out_mask)
);

// File: tb/sim_depth_pipe.sv
module sim_depth_pipe;
    import dpp_pkg::*;

    localparam int N  = 8;
    localparam int DW = 16;
    localparam int NV = 6;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0, in_null = 1'b0;
    logic [2:0]     in_len_m1 = '0;
    logic [DW-1:0]  in_depth = '0, in_incr = '0;
    logic [N-1:0]   in_dirs = '0;
    logic [N*DW-1:0] out_depth;
    logic [N-1:0]   out_mask;
    logic           out_tail_first, out_tail_last;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    always #2.5 clk = ~clk;

    depth_pipe #(.NUM_STAGES(N)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first), .in_last(in_last),
        .in_null(in_null), .in_len_m1(in_len_m1), .in_depth(in_depth), .in_incr(in_incr),
        .in_dirs(in_dirs), .out_depth(out_depth), .out_mask(out_mask),
        .out_tail_first(out_tail_first), .out_tail_last(out_tail_last)
    );

    // {len_m1, depth, incr, dirs}
    localparam logic [42:0] VEC [NV] = '{
        {3'd7, 16'h0100, 16'h0010, 8'h00},
        {3'd7, 16'h1000, 16'h0003, 8'hFF},
        {3'd3, 16'h0050, 16'h0008, 8'hA0},
        {3'd0, 16'h1234, 16'h0FFF, 8'hFF},
        {3'd7, 16'hFFF0, 16'h0004, 8'h00},
        {3'd1, 16'h0000, 16'h0001, 8'h80}
    };

    // Reference model of R1/R2: value seen at stage s.
    function automatic logic [DW-1:0] model(input logic [2:0] lm, input logic [DW-1:0] d,
                                            input logic [DW-1:0] inc, input logic [N-1:0] dr,
                                            input int s);
        logic [DW-1:0] acc = d;
        for (int k = N - int'(lm); k <= s; k++) begin
            acc = dr[k] ? acc - inc : acc + inc;
        end
        return acc;
    endfunction

    function automatic logic [DW-1:0] dep(input int s);
        return out_depth[s*DW +: DW];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic f, input logic l, input logic nl, input logic [2:0] lm,
                         input logic [DW-1:0] d, input logic [DW-1:0] inc, input logic [N-1:0] dr);
        in_valid = 1'b1; in_first = f; in_last = l; in_null = nl;
        in_len_m1 = lm; in_depth = d; in_incr = inc; in_dirs = dr;
        @(negedge clk);
    endtask

    task automatic idle();
        in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0; in_null = 1'b0;
        in_dirs = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R8: reset state
        chk("R8 mask after reset", 32'(out_mask), 32'h0);
        chk("R8 tail_first after reset", 32'(out_tail_first), 32'h0);
        chk("R8 tail_last after reset", 32'(out_tail_last), 32'h0);

        // R1/R2/R9: table of single-plane lists, read at the tail after N edges
        for (int i = 0; i < NV; i++) begin
            logic [2:0]    lm  = VEC[i][42:40];
            logic [DW-1:0] d   = VEC[i][39:24];
            logic [DW-1:0] inc = VEC[i][23:8];
            logic [N-1:0]  dr  = VEC[i][7:0];
            drive(1'b1, 1'b1, 1'b0, lm, d, inc, dr);
            idle();
            repeat (N - 1) @(negedge clk);
            chk("R1 R2 tail depth", 32'(dep(N-1)), 32'(model(lm, d, inc, dr, N-1)));
            chk("R9 tail mask", 32'(out_mask[N-1]), 32'h1);
            chk("R9 tail flags", 32'({out_tail_first, out_tail_last}), 32'h3);
            repeat (2) @(negedge clk);
        end

        // R4/R5: length-one list of two planes, second plane still passive
        drive(1'b1, 1'b0, 1'b0, 3'd0, 16'd100, 16'd5, 8'h00);
        drive(1'b0, 1'b1, 1'b0, 3'd0, 16'd200, 16'd7, 8'h00);
        idle();
        repeat (N - 2) @(negedge clk);
        chk("R4 passive depth unchanged", 32'(dep(N-2)), 32'd200);
        chk("R5 passive stage masked", 32'(out_mask[N-2]), 32'h0);
        chk("R5 start stage unmasked", 32'(out_mask[N-1]), 32'h1);
        chk("R2 start stage reference", 32'(dep(N-1)), 32'd100);
        repeat (3) @(negedge clk);

        // R1/R5: full-length list of two planes, second plane active at stage N-2
        drive(1'b1, 1'b0, 1'b0, 3'd7, 16'd300, 16'd4, 8'h55);
        drive(1'b0, 1'b1, 1'b0, 3'd7, 16'd900, 16'd9, 8'h55);
        idle();
        repeat (N - 2) @(negedge clk);
        chk("R1 second plane depth", 32'(dep(N-2)), 32'(model(3'd7, 16'd900, 16'd9, 8'h55, N-2)));
        chk("R5 active same list unmasked", 32'(out_mask[N-2]), 32'h1);
        repeat (3) @(negedge clk);

        // R3/R6: two lists back to back with opposite directions
        drive(1'b1, 1'b1, 1'b0, 3'd7, 16'd1000, 16'd1, 8'h00);
        drive(1'b1, 1'b1, 1'b0, 3'd7, 16'd5000, 16'd2, 8'hFF);
        idle();
        repeat (N - 2) @(negedge clk);
        chk("R3 earlier list keeps its directions", 32'(dep(N-1)), 32'd1007);
        chk("R6 following list masked", 32'(out_mask[N-2]), 32'h0);
        chk("R3 following list directions", 32'(dep(N-2)), 32'd4988);
        @(negedge clk);
        chk("R3 R6 following list at tail", 32'({out_mask[N-1], dep(N-1)}), {15'h0, 1'b1, 16'd4986});
        repeat (2) @(negedge clk);

        // R7: padding entry never raises a mask bit
        drive(1'b1, 1'b1, 1'b1, 3'd7, 16'd42, 16'd1, 8'h00);
        idle();
        repeat (N - 1) @(negedge clk);
        chk("R7 null entry masked", 32'(out_mask[N-1]), 32'h0);
        repeat (2) @(negedge clk);

        // R8: reset while an entry is in flight discards it
        drive(1'b1, 1'b1, 1'b0, 3'd7, 16'd77, 16'd1, 8'h00);
        idle();
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        repeat (N) @(negedge clk);
        chk("R8 in-flight entry discarded", 32'({out_mask, out_tail_first, out_tail_last}), 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule